// File: doc/BRIEF.md
# Multi-bit sample collector with change filtering

This block watches a 32-bit data bus on every clock and decides which of its values are passed to a downstream valid/ready stream. In continuous collection every enabled cycle produces an output sample. In change collection only values that differ from the most recently loaded output sample are produced, except that the first sample after collection is switched on is always produced. Each produced sample carries a trigger-match flag and a timestamp-request flag for a downstream timestamp source.

Two masked compares run on every sample. The pattern compare and the trigger compare each hold two value/mask word pairs, and a compare hits only when every pair agrees on all of its masked bits. Three independent enables decide whether a pattern hit, a trigger hit, or simply any produced sample asks for a timestamp. All configuration arrives through a single-cycle register write port and takes effect in the cycle after the write.

Top module: `mbc_collector`

## Requirements
- R1: After reset the output stream is idle (out_valid low), and the control word and all pattern and trigger values and masks are zero, so collection is off and every timestamp enable is clear.
- R2: While the enable bit (control bit 0) is clear, no new sample is loaded; a pending sample stays until accepted (out_ready high), after which out_valid is low.
- R3: With enable set and the mode bit (control bit 1) at 0, every cycle loads the bus value, which appears on out_data with out_valid high one clock later.
- R4: With enable set and the mode bit at 1, the first sample after enable is loaded, and each later sample is loaded only if it differs from the value currently held on out_data.
- R5: While out_valid is high and out_ready is low, out_data and its flags hold unless a new sample is loaded, in which case the new sample replaces the pending one.
- R6: The pattern compare hits when, for both pairs i, (sample XOR value_i) AND mask_i is zero; with the pattern timestamp enable (control bit 2) set, a hit raises out_ts of that sample.
- R7: The trigger compare uses the same rule on the trigger pairs; out_trig carries its result for each loaded sample, and with the trigger timestamp enable (control bit 3) set a hit raises out_ts.
- R8: With the all-samples timestamp enable (control bit 4) set, every loaded sample has out_ts high; out_ts is the OR of this enable and the two enabled hits.
- R9: Write addresses: 0 control, 1 and 2 pattern values, 3 and 4 pattern masks, 5 and 6 trigger values, 7 and 8 trigger masks; a write to any other address changes nothing. A write affects samples from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| smp_data | input | 32 | Monitored data bus, sampled every cycle |
| out_ready | input | 1 | Downstream accepts the pending sample |
| out_valid | output | 1 | A sample is pending |
| out_data | output | 32 | Pending sample value |
| out_ts | output | 1 | Timestamp request for the pending sample |
| out_trig | output | 1 | Trigger compare hit for the pending sample |

## Verification
The two functions that meet in one cycle are the downstream handshake and the loading of a new sample: a pending sample may be accepted in the very cycle a new change is loaded, or replaced while the stream is stalled. The bench drives out_ready in random stretches while the bus moves among a few values, some repeating and some matching the pattern and trigger words, so that acceptance, stall hold and replacement all coincide with loads in change mode. A behavioural model advanced every clock predicts valid, data and both flags, and every cycle is judged against it.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    // Control word, bit 0 is the LSB (en)
    typedef struct packed {
        logic ts_all;
        logic ts_trig;
        logic ts_patt;
        logic chg_mode;
        logic en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mbc_cfg.sv
module mbc_cfg
    import mbc_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned NPAT = 2,
    parameter int unsigned AW   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output ctrl_t                     ctrl,
    output logic [NPAT-1:0][DW-1:0]   pval,
    output logic [NPAT-1:0][DW-1:0]   pmsk,
    output logic [NPAT-1:0][DW-1:0]   tval,
    output logic [NPAT-1:0][DW-1:0]   tmsk
);
    localparam int unsigned PVAL_BASE = 1;
    localparam int unsigned PMSK_BASE = PVAL_BASE + NPAT;
    localparam int unsigned TVAL_BASE = PMSK_BASE + NPAT;
    localparam int unsigned TMSK_BASE = TVAL_BASE + NPAT;

    typedef struct packed {
        ctrl_t                   ctrl;
        logic [NPAT-1:0][DW-1:0] pval;
        logic [NPAT-1:0][DW-1:0] pmsk;
        logic [NPAT-1:0][DW-1:0] tval;
        logic [NPAT-1:0][DW-1:0] tmsk;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            if (addr == '0) s_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
            for (int i = 0; i < NPAT; i++) begin
                if (addr == AW'(PVAL_BASE + i)) s_d.pval[i] = wdata;
                if (addr == AW'(PMSK_BASE + i)) s_d.pmsk[i] = wdata;
                if (addr == AW'(TVAL_BASE + i)) s_d.tval[i] = wdata;
                if (addr == AW'(TMSK_BASE + i)) s_d.tmsk[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl = s_q.ctrl;
    assign pval = s_q.pval;
    assign pmsk = s_q.pmsk;
    assign tval = s_q.tval;
    assign tmsk = s_q.tmsk;

    // R9: a write outside the map leaves the control word alone
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && (addr > AW'(TMSK_BASE + NPAT - 1)) |=> $stable(ctrl));

endmodule

// File: rtl/mbc_match.sv
module mbc_match #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NPAT = 2
) (
    input  logic [DW-1:0]             smp,
    input  logic [NPAT-1:0][DW-1:0]   val,
    input  logic [NPAT-1:0][DW-1:0]   msk,
    output logic                      hit
);
    logic [NPAT-1:0] word_ok;

    for (genvar g = 0; g < NPAT; g++) begin : g_word
        assign word_ok[g] = ~|((smp ^ val[g]) & msk[g]);
    end

    assign hit = &word_ok;

endmodule

// File: rtl/mbc_select.sv
module mbc_select
    import mbc_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] smp,
    input  logic          patt_hit,
    input  logic          trig_hit,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_ts,
    output logic          out_trig
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
        logic          ts;
        logic          trig;
        logic          first;
    } sel_st_t;

    sel_st_t s_d, s_q;
    logic    emit;

    always_comb begin
        s_d  = s_q;
        emit = ctrl.en && (!ctrl.chg_mode || s_q.first || (smp != s_q.data));
        if (emit) begin
            s_d.vld   = 1'b1;
            s_d.data  = smp;
            s_d.ts    = ctrl.ts_all | (ctrl.ts_patt & patt_hit) | (ctrl.ts_trig & trig_hit);
            s_d.trig  = trig_hit;
            s_d.first = 1'b0;
        end else if (out_ready) begin
            s_d.vld = 1'b0;
        end
        if (!ctrl.en) s_d.first = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign out_data  = s_q.data;
    assign out_ts    = s_q.ts;
    assign out_trig  = s_q.trig;

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en && (!out_valid || out_ready) |=> !out_valid);

    // R3
    cont_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.en && !ctrl.chg_mode |=> out_valid && (out_data == $past(smp)));

    // R4
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.en && ctrl.chg_mode && !s_q.first && (smp == out_data) && out_ready
        |=> !out_valid);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !ctrl.en |=> out_valid && $stable(out_data) && $stable(out_ts));

    // R8
    ts_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.en && ctrl.ts_all && !ctrl.chg_mode |=> out_valid && out_ts);

endmodule

// File: rtl/mbc_collector.sv
module mbc_collector
    import mbc_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned NPAT = 2,
    parameter int unsigned AW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [DW-1:0] smp_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_ts,
    output logic          out_trig
);
    ctrl_t                   ctrl;
    logic [NPAT-1:0][DW-1:0] pval, pmsk, tval, tmsk;
    logic                    patt_hit, trig_hit;

    mbc_cfg #(.DW(DW), .NPAT(NPAT), .AW(AW)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .pval  (pval),
        .pmsk  (pmsk),
        .tval  (tval),
        .tmsk  (tmsk)
    );

    mbc_match #(.DW(DW), .NPAT(NPAT)) i_patt (
        .smp (smp_data),
        .val (pval),
        .msk (pmsk),
        .hit (patt_hit)
    );

    mbc_match #(.DW(DW), .NPAT(NPAT)) i_trig (
        .smp (smp_data),
        .val (tval),
        .msk (tmsk),
        .hit (trig_hit)
    );

    mbc_select #(.DW(DW)) i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .smp       (smp_data),
        .patt_hit  (patt_hit),
        .trig_hit  (trig_hit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ts    (out_ts),
        .out_trig  (out_trig)
    );

    // R1: nothing is pending in the first cycle after reset
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/test_mbc_collector.sv
`timescale 1ns/1ps
module test_mbc_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] smp_data = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ts;
    logic        out_trig;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    bit          m_en, m_chg, m_tsp, m_tst, m_tsall;
    logic [31:0] mpv [2];
    logic [31:0] mpm [2];
    logic [31:0] mtv [2];
    logic [31:0] mtm [2];
    bit          m_valid, m_ts, m_trig, m_first;
    logic [31:0] m_data;

    logic [31:0] pool [4];

    always #5 clk = ~clk;

    mbc_collector i_mbc_collector (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .smp_data  (smp_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ts    (out_ts),
        .out_trig  (out_trig)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit hp = 1, ht = 1, emit;
        for (int i = 0; i < 2; i++) begin
            if (((smp_data ^ mpv[i]) & mpm[i]) != 0) hp = 0;
            if (((smp_data ^ mtv[i]) & mtm[i]) != 0) ht = 0;
        end
        emit = m_en && (!m_chg || m_first || (smp_data != m_data));
        if (emit) begin
            m_valid = 1; m_data = smp_data; m_trig = ht; m_first = 0;
            m_ts = m_tsall || (m_tsp && hp) || (m_tst && ht);
        end else if (out_ready) begin
            m_valid = 0;
        end
        if (!m_en) m_first = 1;
        if (cfg_we) begin
            case (cfg_addr)
                4'd0: {m_tsall, m_tst, m_tsp, m_chg, m_en} = cfg_wdata[4:0];
                4'd1: mpv[0] = cfg_wdata;
                4'd2: mpv[1] = cfg_wdata;
                4'd3: mpm[0] = cfg_wdata;
                4'd4: mpm[1] = cfg_wdata;
                4'd5: mtv[0] = cfg_wdata;
                4'd6: mtv[1] = cfg_wdata;
                4'd7: mtm[0] = cfg_wdata;
                4'd8: mtm[1] = cfg_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        check(out_valid == m_valid, "R2 R3 R4 R5 out_valid", 32'(out_valid), 32'(m_valid));
        if (m_valid) begin
            check(out_data == m_data, "R3 R4 R5 out_data", out_data, m_data);
            check(out_ts == m_ts, "R6 R7 R8 out_ts", 32'(out_ts), 32'(m_ts));
            check(out_trig == m_trig, "R7 out_trig", 32'(out_trig), 32'(m_trig));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        model_step();
        compare();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic run(input int n, input int rdy_pct, input int max_idx);
        for (int k = 0; k < n; k++) begin
            smp_data  = pool[$urandom_range(0, max_idx)];
            out_ready = ($urandom_range(0, 99) < rdy_pct);
            tick();
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        pool[0] = 32'h0000_0000;
        pool[1] = 32'hA5A5_0001;
        pool[2] = 32'hA5A5_0002;
        pool[3] = 32'h1234_5678;
        m_first = 1;
        for (int i = 0; i < 2; i++) begin
            mpv[i] = '0; mpm[i] = '0; mtv[i] = '0; mtm[i] = '0;
        end
        m_data = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        check(out_valid == 0, "R1 idle after reset", 32'(out_valid), 0);

        // R2: inputs move but collection is off
        run(5, 100, 3);
        check(out_valid == 0, "R2 no load while disabled", 32'(out_valid), 0);

        // R1: enable only; timestamp enables and masks still zero
        smp_data = pool[1];
        wr(4'd0, 32'h1);
        out_ready = 1;
        tick();
        check(out_valid && !out_ts && out_trig, "R1 reset config zero", {29'd0, out_valid, out_ts, out_trig}, 32'h5);

        // R3: continuous with random stalls
        run(30, 60, 3);

        // R4: change mode, first sample always loaded
        wr(4'd0, 32'h0);
        tick();
        smp_data = 32'hAAAA_5555; out_ready = 1;
        wr(4'd0, 32'h3);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (out_valid) cnt++;
        end
        check(cnt == 1, "R4 single load of constant bus", cnt, 1);
        run(60, 50, 3);

        // R6 R7: pattern and trigger words
        wr(4'd1, 32'hA5A5_0000);
        wr(4'd3, 32'hFFFF_0000);
        wr(4'd2, 32'h0000_0001);
        wr(4'd4, 32'h0000_0001);
        wr(4'd5, 32'h1234_5678);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd0, 32'h7);            // change mode, pattern ts
        run(40, 50, 3);
        wr(4'd0, 32'hB);            // change mode, trigger ts
        run(40, 50, 3);
        wr(4'd0, 32'h5);            // continuous, pattern ts
        run(30, 70, 3);
        smp_data = pool[1]; out_ready = 1;
        tick(); tick();
        check(out_ts == 1, "R6 pattern hit requests timestamp", 32'(out_ts), 1);

        // R8: all-samples timestamp
        wr(4'd0, 32'h13);
        run(40, 50, 3);

        // R9: writes outside the map change nothing
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd15, 32'h0);
        run(20, 50, 3);
        smp_data = pool[0]; out_ready = 1;
        tick(); tick();
        check(out_ts == 1, "R9 ignored addresses keep control", 32'(out_ts), 1);

        // R5: stall then replace in change mode
        wr(4'd0, 32'h3);
        out_ready = 0;
        smp_data = 32'h0000_00F0; tick();
        smp_data = 32'h0000_00F0; tick(); tick();
        check(out_data == 32'hF0, "R5 held while stalled", out_data, 32'hF0);
        smp_data = 32'h0000_00F1; tick();
        check(out_data == 32'hF1 && out_valid, "R5 replaced while stalled", out_data, 32'hF1);

        // R2: disable with pending sample, then drain
        wr(4'd0, 32'h0);
        run(20, 40, 3);
        out_ready = 1; tick(); tick();
        check(out_valid == 0, "R2 drained after disable", 32'(out_valid), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule